// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block watches an audio master clock and the frame clock (one period per stereo sample) derived from it, and works out how many master clock cycles make up one frame. Once the count is steady and belongs to the set of ratios the data path supports, the block reports the ratio as a code, classifies the stream into a single-, double- or quad-rate band, and raises a locked flag. A downstream converter uses these outputs to set its internal dividers and filters.

The ratio alone does not fix the sample rate, because the same ratio is used at different rates. The block therefore also measures the absolute master clock frequency. It counts master clock cycles over a fixed window of a free-running reference clock. From both numbers it estimates the sample rate and picks the band. While nothing is known, and while the clocking is changing, the block requests zero data on the audio path through its mute output. After a fresh lock it keeps that request for a programmable number of frames, so the analog side can settle. If the frame clock stops, the block falls back to its power-down state.

Top module: `aud_ratio_detect`

## Requirements
- R1: After reset, and whenever `locked` is 0, `mute` is 1 and both `ratio_code` and `speed_mode` read 0. The block stays in this power-down state until the frame clock produces complete periods.
- R2: The ratio is the number of master clock cycles between two consecutive rising edges of `frame_clk`. Only these ratios are legal, and each has a code: 64→1, 96→2, 128→3, 192→4, 256→5, 384→6, 512→7, 768→8, 1024→9, 1152→10.
- R3: `locked` rises once two consecutive frame measurements are equal and legal, and the master clock rate is known. With a steady stream this happens after the third rising frame edge.
- R4: A frame length that is not in the legal set never produces lock, and `ratio_code` stays 0.
- R5: While locked, a frame measurement that differs from the locked ratio drops `locked`, clears `ratio_code` and `speed_mode`, and forces `mute`. The ratio code never changes while `locked` stays high.
- R6: `speed_mode` is 1 (single, about 32–48 kHz frames), 2 (double, about 64–96 kHz) or 3 (quad, about 128–192 kHz). It is chosen from the estimated frame rate (measured master clock rate divided by the ratio), with band edges near 56 kHz and 112 kHz.
- R7: On the cycle `locked` rises, `mute` is still 1. `mute` falls only after `SETTLE_FRAMES` further frame measurements agree with the locked ratio; with `SETTLE_FRAMES`=4 that is after the fourth rising edge following the locking edge.
- R8: While locked, a change of master clock rate that moves the band drops `locked` and forces `mute`. Lock then returns with the new band, and the settling count starts over.
- R9: If no rising frame edge arrives within `TIMEOUT_CYC` master clock cycles after the last one, the block returns to the power-down state of R1.
- R10: When the frame clock resumes after a timeout, the block locks again as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Audio master clock; all outputs are in this domain |
| frame_clk | input | 1 | Frame clock, one period per stereo sample, synchronous to mclk |
| ref_clk | input | 1 | Free-running reference clock used to time the master clock rate window |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | output | 4 | Code of the locked master-to-frame ratio, 0 when not locked |
| speed_mode | output | 2 | Rate band: 0 none, 1 single, 2 double, 3 quad |
| locked | output | 1 | A legal, stable ratio has been accepted |
| mute | output | 1 | Request for zero data on the audio path |

## Verification
The bench samples the outputs on both sides of each frame-edge boundary: the locking edge, the last muted edge and the first unmuted edge. A design that locked on a single measurement, or that counted the settling window one frame off, fails at one of these points. The bench changes the ratio and the master clock rate in the middle of the stream. A design that never compared new measurements with the locked value, or that froze the band at lock, would stay locked with a stale code or band. The bench also covers the smallest and largest legal ratios, a frame length outside the set, and a stopped frame clock followed by a restart. These catch decoders that map ratios to the wrong codes and timeouts that never fire or never recover.

// File: rtl/ard_pkg.sv
`timescale 1ns/1ps
package ard_pkg;

  typedef enum logic [1:0] {
    SPD_NONE   = 2'd0,
    SPD_SINGLE = 2'd1,
    SPD_DOUBLE = 2'd2,
    SPD_QUAD   = 2'd3
  } speed_e;

  typedef enum logic [1:0] {
    ST_PWRDN = 2'd0,
    ST_ACQ   = 2'd1,
    ST_LOCK  = 2'd2
  } lock_st_e;

  // Maps a measured frame length onto its ratio code; 0 marks an illegal length.
  function automatic logic [3:0] code_of(input int unsigned n);
    case (n)
      64:      code_of = 4'd1;
      96:      code_of = 4'd2;
      128:     code_of = 4'd3;
      192:     code_of = 4'd4;
      256:     code_of = 4'd5;
      384:     code_of = 4'd6;
      512:     code_of = 4'd7;
      768:     code_of = 4'd8;
      1024:    code_of = 4'd9;
      1152:    code_of = 4'd10;
      default: code_of = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/ard_rst_sync.sv
`timescale 1ns/1ps
module ard_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];

endmodule

// File: rtl/ard_ref_window.sv
`timescale 1ns/1ps
// Reference-domain timer: toggles win_tgl once every REF_WIN reference cycles.
module ard_ref_window #(
  parameter int REF_WIN = 256,
  parameter int CNT_W   = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_tgl
);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             tgl_nx;

  always_comb begin
    cnt_nx = cnt_q + 1'b1;
    tgl_nx = win_tgl;
    if (cnt_q == CNT_W'(REF_WIN - 1)) begin
      cnt_nx = '0;
      tgl_nx = ~win_tgl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      win_tgl <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      win_tgl <= tgl_nx;
    end
  end

endmodule

// File: rtl/ard_rate_meter.sv
`timescale 1ns/1ps
// Counts master clock cycles between successive window toggles.
module ard_rate_meter #(
  parameter int RATE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_tgl,
  output logic [RATE_W-1:0] rate,
  output logic              rate_vld
);

  localparam logic [RATE_W-1:0] CNT_MAX = '1;

  logic [2:0]        sync_q;
  logic [RATE_W-1:0] cnt_q, cnt_nx, rate_nx;
  logic              armed_q, armed_nx, vld_nx;
  logic              win_edge;

  assign win_edge = sync_q[2] ^ sync_q[1];

  always_comb begin
    cnt_nx   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    rate_nx  = rate;
    armed_nx = armed_q;
    vld_nx   = rate_vld;
    if (win_edge) begin
      cnt_nx   = '0;
      armed_nx = 1'b1;
      if (armed_q) begin
        rate_nx = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        vld_nx  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      cnt_q    <= '0;
      rate     <= '0;
      armed_q  <= 1'b0;
      rate_vld <= 1'b0;
    end else begin
      sync_q   <= {sync_q[1:0], win_tgl};
      cnt_q    <= cnt_nx;
      rate     <= rate_nx;
      armed_q  <= armed_nx;
      rate_vld <= vld_nx;
    end
  end

endmodule

// File: rtl/ard_frame_meter.sv
`timescale 1ns/1ps
// Measures master clock cycles per frame and flags a missing frame clock.
module ard_frame_meter #(
  parameter int TMO    = 2048,
  parameter int FCNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_clk,
  output logic [FCNT_W-1:0] meas,
  output logic              meas_vld,
  output logic              tmo
);

  localparam logic [FCNT_W-1:0] CNT_SAT  = FCNT_W'(TMO);
  localparam logic [FCNT_W-1:0] CNT_LAST = FCNT_W'(TMO - 1);

  logic              fc_s_q, fc_p_q, rise;
  logic [FCNT_W-1:0] cnt_q, cnt_nx, meas_nx;
  logic              have_q, have_nx, vld_nx, tmo_nx;

  assign rise = fc_s_q & ~fc_p_q;

  always_comb begin
    cnt_nx  = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
    have_nx = have_q;
    meas_nx = meas;
    vld_nx  = 1'b0;
    tmo_nx  = 1'b0;
    if (rise) begin
      cnt_nx  = '0;
      have_nx = 1'b1;
      if (have_q) begin
        meas_nx = cnt_q + 1'b1;
        vld_nx  = 1'b1;
      end
    end else if (have_q && cnt_q == CNT_LAST) begin
      have_nx = 1'b0;
      tmo_nx  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_s_q   <= 1'b0;
      fc_p_q   <= 1'b0;
      cnt_q    <= '0;
      have_q   <= 1'b0;
      meas     <= '0;
      meas_vld <= 1'b0;
      tmo      <= 1'b0;
    end else begin
      fc_s_q   <= frame_clk;
      fc_p_q   <= fc_s_q;
      cnt_q    <= cnt_nx;
      have_q   <= have_nx;
      meas     <= meas_nx;
      meas_vld <= vld_nx;
      tmo      <= tmo_nx;
    end
  end

endmodule

// File: rtl/aud_ratio_detect.sv
`timescale 1ns/1ps
module aud_ratio_detect #(
  parameter int REF_WIN       = 256,   // reference cycles per rate window
  parameter int TIMEOUT_CYC   = 2048,  // master cycles without a frame edge
  parameter int SETTLE_FRAMES = 2048,  // agreeing frames before unmute
  parameter int K_SHIFT       = 10,    // scale of the band constants
  parameter int K_DQ          = 294,   // double/quad edge, scaled to the window
  parameter int K_SD          = 147    // single/double edge, scaled to the window
) (
  input  logic       mclk,
  input  logic       frame_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  output logic [3:0] ratio_code,
  output logic [1:0] speed_mode,
  output logic       locked,
  output logic       mute
);

  import ard_pkg::*;

  localparam int WIN_W  = $clog2(REF_WIN);
  localparam int RATE_W = $clog2(REF_WIN) + 2;
  localparam int FCNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam int SET_W  = $clog2(SETTLE_FRAMES + 1);
  localparam int PW     = RATE_W + FCNT_W + K_SHIFT + 2;

  logic              m_rst_n, r_rst_n;
  logic              win_tgl;
  logic [RATE_W-1:0] rate;
  logic              rate_vld;
  logic [FCNT_W-1:0] meas;
  logic              meas_vld, frm_tmo;

  ard_rst_sync u_rst_m (.clk(mclk),    .rst_n_in(rst_n), .rst_n_out(m_rst_n));
  ard_rst_sync u_rst_r (.clk(ref_clk), .rst_n_in(rst_n), .rst_n_out(r_rst_n));

  ard_ref_window #(.REF_WIN(REF_WIN), .CNT_W(WIN_W)) u_win (
    .clk(ref_clk), .rst_n(r_rst_n), .win_tgl(win_tgl)
  );

  ard_rate_meter #(.RATE_W(RATE_W)) u_rate (
    .clk(mclk), .rst_n(m_rst_n), .win_tgl(win_tgl), .rate(rate), .rate_vld(rate_vld)
  );

  ard_frame_meter #(.TMO(TIMEOUT_CYC), .FCNT_W(FCNT_W)) u_frm (
    .clk(mclk), .rst_n(m_rst_n), .frame_clk(frame_clk),
    .meas(meas), .meas_vld(meas_vld), .tmo(frm_tmo)
  );

  lock_st_e          st_q, st_nx;
  logic [FCNT_W-1:0] cand_q, cand_nx;
  logic [3:0]        code_q, code_nx, meas_code;
  speed_e            spd_q, spd_nx, spd_now;
  logic [SET_W-1:0]  settle_q, settle_nx;
  logic [PW-1:0]     rate_scaled, edge_dq, edge_sd;
  logic              settled;

  // Estimated frame rate against the band edges: rate/ratio vs K/2^K_SHIFT.
  always_comb begin
    rate_scaled = PW'(rate) << K_SHIFT;
    edge_dq     = PW'(cand_q) * PW'(K_DQ);
    edge_sd     = PW'(cand_q) * PW'(K_SD);
    if (rate_scaled > edge_dq)      spd_now = SPD_QUAD;
    else if (rate_scaled > edge_sd) spd_now = SPD_DOUBLE;
    else                            spd_now = SPD_SINGLE;
  end

  assign meas_code = code_of(32'(meas));
  assign settled   = (settle_q == SET_W'(SETTLE_FRAMES));

  always_comb begin
    st_nx     = st_q;
    cand_nx   = cand_q;
    code_nx   = code_q;
    spd_nx    = spd_q;
    settle_nx = settle_q;
    if (frm_tmo) begin
      st_nx     = ST_PWRDN;
      code_nx   = '0;
      spd_nx    = SPD_NONE;
      settle_nx = '0;
    end else begin
      case (st_q)
        ST_PWRDN: begin
          if (meas_vld) begin
            cand_nx = meas;
            st_nx   = ST_ACQ;
          end
        end
        ST_ACQ: begin
          if (meas_vld) begin
            cand_nx = meas;
            if (meas == cand_q && meas_code != 4'd0 && rate_vld) begin
              st_nx     = ST_LOCK;
              code_nx   = meas_code;
              spd_nx    = spd_now;
              settle_nx = '0;
            end
          end
        end
        ST_LOCK: begin
          if (meas_vld && meas != cand_q) begin
            st_nx   = ST_ACQ;
            cand_nx = meas;
            code_nx = '0;
            spd_nx  = SPD_NONE;
          end else if (spd_now != spd_q) begin
            st_nx   = ST_ACQ;
            code_nx = '0;
            spd_nx  = SPD_NONE;
          end else if (meas_vld && !settled) begin
            settle_nx = settle_q + 1'b1;
          end
        end
        default: st_nx = ST_PWRDN;
      endcase
    end
  end

  always_ff @(posedge mclk or negedge m_rst_n) begin
    if (!m_rst_n) begin
      st_q     <= ST_PWRDN;
      cand_q   <= '0;
      code_q   <= '0;
      spd_q    <= SPD_NONE;
      settle_q <= '0;
    end else begin
      st_q     <= st_nx;
      cand_q   <= cand_nx;
      code_q   <= code_nx;
      spd_q    <= spd_nx;
      settle_q <= settle_nx;
    end
  end

  assign ratio_code = code_q;
  assign speed_mode = spd_q;
  assign locked     = (st_q == ST_LOCK);
  assign mute       = !(locked && settled);

endmodule

// File: rtl/aud_ratio_detect_chk.sv
`timescale 1ns/1ps
module aud_ratio_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tmo,
  input logic       locked,
  input logic       mute,
  input logic [3:0] ratio_code,
  input logic [1:0] speed_mode
);

  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (mute && ratio_code == 4'd0 && speed_mode == 2'd0));

  a_r2_locked_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (ratio_code != 4'd0 && ratio_code <= 4'd10 && speed_mode != 2'd0));

  a_r5_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(ratio_code));

  a_r7_muted_at_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> mute);

  a_r7_unmute_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> locked);

  a_r9_timeout_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !locked);

endmodule

bind aud_ratio_detect aud_ratio_detect_chk u_chk (
  .clk(mclk), .rst_n(m_rst_n), .tmo(frm_tmo), .locked(locked), .mute(mute),
  .ratio_code(ratio_code), .speed_mode(speed_mode)
);

// File: tb/aud_ratio_detect_tb.sv
`timescale 1ns/1ps
module aud_ratio_detect_tb;

  typedef struct packed {
    logic [3:0] code;
    logic [1:0] spd;
    logic       lck;
    logic       mt;
  } exp_t;

  logic       mclk = 1'b0, ref_clk = 1'b0, frame_clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ratio_code;
  logic [1:0] speed_mode;
  logic       locked, mute;

  realtime mhalf = 40.690;
  int      cur_ratio = 256;
  bit      run_fc = 1'b0;
  int      rise_cnt = 0;
  int      checks = 0, errors = 0;
  bit      done = 1'b0;
  exp_t    exp_q[$];
  string   tag_q[$];

  aud_ratio_detect #(.SETTLE_FRAMES(4)) u_dut (
    .mclk(mclk), .frame_clk(frame_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .ratio_code(ratio_code), .speed_mode(speed_mode), .locked(locked), .mute(mute)
  );

  always #5 ref_clk = ~ref_clk;
  initial forever #(mhalf) mclk = ~mclk;

  // Frame clock generator: each period is cur_ratio master cycles, half high.
  initial begin
    forever begin
      if (!run_fc) begin
        @(negedge mclk);
        frame_clk = 1'b0;
      end else begin
        automatic int r = cur_ratio;
        @(negedge mclk);
        frame_clk = 1'b1;
        rise_cnt++;
        repeat (r / 2 - 1) @(negedge mclk);
        @(negedge mclk);
        frame_clk = 1'b0;
        repeat (r - r / 2 - 1) @(negedge mclk);
      end
    end
  end

  task automatic wait_rises(input int n);
    automatic int target = rise_cnt + n;
    wait (rise_cnt >= target);
    repeat (8) @(negedge mclk);
  endtask

  task automatic expect_now(input logic [3:0] c, input logic [1:0] s,
                            input logic l, input logic m, input string tag);
    exp_t e;
    e.code = c; e.spd = s; e.lck = l; e.mt = m;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: pops expected items and compares them against the outputs.
  initial begin
    forever begin
      exp_t  e;
      exp_t  a;
      string t;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a.code = ratio_code; a.spd = speed_mode; a.lck = locked; a.mt = mute;
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual code=%0d spd=%0d locked=%0b mute=%0b expected code=%0d spd=%0d locked=%0b mute=%0b",
                 t, a.code, a.spd, a.lck, a.mt, e.code, e.spd, e.lck, e.mt);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge ref_clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20) @(posedge ref_clk);
    rst_n = 1'b1;
    repeat (60) @(posedge ref_clk);
    @(negedge mclk);
    expect_now(4'd0, 2'd0, 1'b0, 1'b1, "R1 reset, no frame clock");

    // 12.288 MHz, ratio 256: 48 kHz single band
    run_fc = 1'b1;
    wait_rises(3);
    expect_now(4'd5, 2'd1, 1'b1, 1'b1, "R3 lock after third edge, R2 code 256, R6 single");
    wait_rises(3);
    expect_now(4'd5, 2'd1, 1'b1, 1'b1, "R7 still muted after three settle frames");
    wait_rises(1);
    expect_now(4'd5, 2'd1, 1'b1, 1'b0, "R7 unmuted after fourth settle frame");

    // Ratio 128: 96 kHz double band
    cur_ratio = 128;
    wait_rises(2);
    expect_now(4'd0, 2'd0, 1'b0, 1'b1, "R5 ratio change drops lock");
    wait_rises(1);
    expect_now(4'd3, 2'd2, 1'b1, 1'b1, "R3 relock code 128, R6 double");

    // Master clock doubled, same ratio: 192 kHz quad band
    wait_rises(5);
    mhalf = 20.345;
    wait_rises(3);
    expect_now(4'd3, 2'd3, 1'b1, 1'b1, "R8 rate change relocks quad, settle restarted");
    wait_rises(6);
    expect_now(4'd3, 2'd3, 1'b1, 1'b0, "R8 unmuted after new settle window");

    // Illegal frame length
    cur_ratio = 200;
    wait_rises(6);
    expect_now(4'd0, 2'd0, 1'b0, 1'b1, "R4 illegal ratio 200 never locks");

    // Smallest ratio: 8.192 MHz / 64 = 128 kHz quad
    mhalf = 61.035;
    cur_ratio = 64;
    wait_rises(4);
    expect_now(4'd1, 2'd3, 1'b1, 1'b1, "R2 code 64, R6 quad at 128 kHz");

    // Largest ratio: 36.864 MHz / 1152 = 32 kHz single
    mhalf = 13.563;
    cur_ratio = 1152;
    wait_rises(4);
    expect_now(4'd10, 2'd1, 1'b1, 1'b1, "R2 code 1152, R6 single at 32 kHz");

    // Frame clock stops
    run_fc = 1'b0;
    repeat (3500) @(negedge mclk);
    expect_now(4'd0, 2'd0, 1'b0, 1'b1, "R9 timeout returns to power-down");

    run_fc = 1'b1;
    wait_rises(3);
    expect_now(4'd10, 2'd1, 1'b1, 1'b1, "R10 relock after frame clock resumes");

    wait (exp_q.size() == 0);
    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule